// File: doc/BRIEF.md
# Serial Image Download Controller

This block sequences a byte-level download session with a host once the serial link has been brought to the right speed. After a start pulse it waits for a sync byte from the host. It then reads every location of the nonvolatile user area, and if any location is not blank it issues one erase of the whole array. When the array is blank it acknowledges, receives a two-byte image length, and copies the image byte by byte into a fixed RAM window. Every byte it receives during this phase is echoed back to the host. After the last byte it signals a jump to the start of the window.

The serial port, the nonvolatile array, the RAM and the processor all sit outside the block. It talks to them through simple strobes. If the erase fails, or if the length is not allowed, the block sends an error code and then stops. It does nothing more until the next reset.

Top module: `boot_dl_ctrl`

## Requirements
- R1: After reset, and until `start_i` has been seen, all output strobes are low and received bytes are ignored.
- R2: After start, the block waits for the sync byte 0x55. Any other byte is dropped and gets no reply.
- R3: The blank scan reads addresses from 0 up to a limit. The limit is `BLANK_END0` when `mode_i`=0 and `BLANK_END1` when `mode_i`=1. Read data is sampled one cycle after `nvm_rd_o`. The first location that does not read 0xFF causes exactly one single-cycle `erase_req_o`.
- R4: If `erase_fail_i` is reported, the block sends 0xFF and halts. Later bytes get no echo and cause no RAM write.
- R5: When the scan finds the array blank, or `erase_done_i` is reported, the block sends 0xAA.
- R6: The length arrives as two bytes, high byte first. Each of the two bytes is echoed as it is received.
- R7: A length of 0, or a length greater than `RAM_BYTES`, is rejected. The block sends 0xEE after the low-byte echo and then halts without any RAM write.
- R8: Program byte i is echoed, and is written to address `RAM_BASE`+i with a one-cycle `ram_we_o` in the cycle after it is accepted.
- R9: After the echo of the last byte, the block sends 0xAA. It then holds `jump_o` high with `jump_addr_o`=`RAM_BASE`.
- R10: `tx_valid_o` keeps `tx_data_o` steady until `tx_ready_i`. A byte that arrives while a reply is still waiting for hand-off is dropped.
- R11: A length of exactly `RAM_BYTES` is accepted. With the default values, the last byte is written to 0xFF6D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | pulse: link speed aligned, begin session |
| mode_i | input | 1 | selects blank-scan limit |
| rx_valid_i | input | 1 | received byte valid, one cycle |
| rx_data_i | input | 8 | received byte |
| tx_ready_i | input | 1 | transmitter can take a byte |
| tx_valid_o | output | 1 | byte offered to transmitter |
| tx_data_o | output | 8 | byte to transmit |
| nvm_rd_o | output | 1 | nonvolatile read strobe |
| nvm_addr_o | output | ADDR_W | nonvolatile read address |
| nvm_rdata_i | input | 8 | read data, valid the cycle after the strobe |
| erase_req_o | output | 1 | whole-array erase request, one cycle |
| erase_done_i | input | 1 | erase finished successfully |
| erase_fail_i | input | 1 | erase failed |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| jump_o | output | 1 | request to run the loaded image |
| jump_addr_o | output | ADDR_W | image entry address |

## Verification
A received byte is accepted at a clock edge. Its echo appears on `tx_valid_o` in the following cycle, and the RAM write strobe is high in that same cycle. The final acknowledge comes two cycles after the last echo is handed off, and `jump_o` rises once that acknowledge is taken. Each scan location costs two cycles, so the first reply after sync is due roughly two cycles per location later, plus the erase time. The bench drives inputs on the falling edge and samples one nanosecond after it. It polls once per cycle for each expected byte with a bounded wait instead of assuming a fixed latency. Checks for dropped bytes wait several cycles past the point at which an echo would have shown up.

// File: rtl/bdl_pkg.sv
`timescale 1ns/1ps
package bdl_pkg;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 2 * DATA_W;

  localparam logic [DATA_W-1:0] SYNC_BYTE    = 8'h55;
  localparam logic [DATA_W-1:0] ACK_BYTE     = 8'hAA;
  localparam logic [DATA_W-1:0] BLANK_BYTE   = 8'hFF;
  localparam logic [DATA_W-1:0] ERA_ERR_BYTE = 8'hFF;
  localparam logic [DATA_W-1:0] LEN_ERR_BYTE = 8'hEE;

  typedef enum logic [3:0] {
    S_IDLE, S_SYNC, S_SCAN_RD, S_SCAN_CK, S_ERASE, S_ERASE_WT,
    S_LEN_HI, S_LEN_LO, S_DATA, S_LEN_ERR, S_FIN, S_TX, S_HALT, S_JUMP
  } st_e;
endpackage

// File: rtl/bdl_blank_scan.sv
`timescale 1ns/1ps
module bdl_blank_scan #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] END0   = 'hEF7F,
  parameter logic [ADDR_W-1:0] END1   = 'hF77F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == (mode_i ? END1 : END0));
endmodule

// File: rtl/bdl_img_cnt.sv
`timescale 1ns/1ps
module bdl_img_cnt #(
  parameter int                ADDR_W = 16,
  parameter int                LEN_W  = 16,
  parameter logic [ADDR_W-1:0] BASE   = 'hF7E0,
  parameter int                BYTES  = 1934
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int OFF_W = $clog2(BYTES);

  logic [LEN_W-1:0] left_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      left_q <= len_i;
      off_q  <= '0;
    end else if (step_i) begin
      left_q <= left_q - 1'b1;
      off_q  <= off_q + 1'b1;
    end
  end

  assign addr_o = BASE + ADDR_W'(off_q);
  assign last_o = (left_q == LEN_W'(1));
endmodule

// File: rtl/boot_dl_ctrl.sv
`timescale 1ns/1ps
module boot_dl_ctrl
  import bdl_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 'hF7E0,
  parameter int                RAM_BYTES  = 1934,
  parameter logic [ADDR_W-1:0] BLANK_END0 = 'hEF7F,
  parameter logic [ADDR_W-1:0] BLANK_END1 = 'hF77F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              nvm_rd_o,
  output logic [ADDR_W-1:0] nvm_addr_o,
  input  logic [7:0]        nvm_rdata_i,
  output logic              erase_req_o,
  input  logic              erase_done_i,
  input  logic              erase_fail_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              jump_o,
  output logic [ADDR_W-1:0] jump_addr_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(RAM_BYTES);

  st_e               st_q, st_d, ret_q, ret_d;
  logic [DATA_W-1:0] txb_q, txb_d, hi_q, hi_d;
  logic              scan_clr, scan_inc, scan_last;
  logic              img_load, img_step, img_last;
  logic [ADDR_W-1:0] img_addr;
  logic [LEN_W-1:0]  len_full;
  logic              len_bad;
  logic              ram_we_q;
  logic [ADDR_W-1:0] ram_addr_q;
  logic [DATA_W-1:0] ram_wdata_q;

  bdl_blank_scan #(.ADDR_W(ADDR_W), .END0(BLANK_END0), .END1(BLANK_END1)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .clr_i  (scan_clr),
    .inc_i  (scan_inc),
    .addr_o (nvm_addr_o),
    .last_o (scan_last)
  );

  bdl_img_cnt #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BASE(RAM_BASE), .BYTES(RAM_BYTES)) u_img (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (img_load),
    .len_i  (len_full),
    .step_i (img_step),
    .addr_o (img_addr),
    .last_o (img_last)
  );

  assign len_full = {hi_q, rx_data_i};
  assign len_bad  = (len_full == '0) || (len_full > MAX_LEN);

  always_comb begin
    st_d     = st_q;
    ret_d    = ret_q;
    txb_d    = txb_q;
    hi_d     = hi_q;
    scan_clr = 1'b0;
    scan_inc = 1'b0;
    img_load = 1'b0;
    img_step = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_SYNC;
      S_SYNC: if (rx_valid_i && rx_data_i == SYNC_BYTE) begin
        scan_clr = 1'b1;
        st_d     = S_SCAN_RD;
      end
      S_SCAN_RD: st_d = S_SCAN_CK;
      S_SCAN_CK: begin
        if (nvm_rdata_i != BLANK_BYTE) st_d = S_ERASE;
        else if (scan_last) begin
          st_d = S_TX; txb_d = ACK_BYTE; ret_d = S_LEN_HI;
        end else begin
          scan_inc = 1'b1;
          st_d     = S_SCAN_RD;
        end
      end
      S_ERASE: st_d = S_ERASE_WT;
      S_ERASE_WT: begin
        if (erase_fail_i) begin
          st_d = S_TX; txb_d = ERA_ERR_BYTE; ret_d = S_HALT;
        end else if (erase_done_i) begin
          st_d = S_TX; txb_d = ACK_BYTE; ret_d = S_LEN_HI;
        end
      end
      S_LEN_HI: if (rx_valid_i) begin
        hi_d = rx_data_i;
        st_d = S_TX; txb_d = rx_data_i; ret_d = S_LEN_LO;
      end
      S_LEN_LO: if (rx_valid_i) begin
        st_d = S_TX; txb_d = rx_data_i;
        if (len_bad) ret_d = S_LEN_ERR;
        else begin
          img_load = 1'b1;
          ret_d    = S_DATA;
        end
      end
      S_DATA: if (rx_valid_i) begin
        img_step = 1'b1;
        st_d  = S_TX; txb_d = rx_data_i;
        ret_d = img_last ? S_FIN : S_DATA;
      end
      S_LEN_ERR: begin st_d = S_TX; txb_d = LEN_ERR_BYTE; ret_d = S_HALT; end
      S_FIN:     begin st_d = S_TX; txb_d = ACK_BYTE;     ret_d = S_JUMP; end
      S_TX:      if (tx_ready_i) st_d = ret_q;
      S_HALT, S_JUMP: ;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      ret_q <= S_IDLE;
      txb_q <= '0;
      hi_q  <= '0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      txb_q <= txb_d;
      hi_q  <= hi_d;
    end
  end

  // write pulse trails acceptance by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_we_q    <= 1'b0;
      ram_addr_q  <= '0;
      ram_wdata_q <= '0;
    end else begin
      ram_we_q <= img_step;
      if (img_step) begin
        ram_addr_q  <= img_addr;
        ram_wdata_q <= rx_data_i;
      end
    end
  end

  assign tx_valid_o  = (st_q == S_TX);
  assign tx_data_o   = txb_q;
  assign nvm_rd_o    = (st_q == S_SCAN_RD);
  assign erase_req_o = (st_q == S_ERASE);
  assign ram_we_o    = ram_we_q;
  assign ram_addr_o  = ram_addr_q;
  assign ram_wdata_o = ram_wdata_q;
  assign jump_o      = (st_q == S_JUMP);
  assign jump_addr_o = RAM_BASE;
endmodule

// File: rtl/bdl_chk.sv
`timescale 1ns/1ps
module bdl_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 'hF7E0,
  parameter int                RAM_BYTES  = 1934,
  parameter logic [ADDR_W-1:0] BLANK_END0 = 'hEF7F,
  parameter logic [ADDR_W-1:0] BLANK_END1 = 'hF77F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              rx_valid_i,
  input logic              tx_ready_i,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              nvm_rd_o,
  input logic [ADDR_W-1:0] nvm_addr_o,
  input logic              erase_req_o,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              jump_o
);
  localparam logic [ADDR_W-1:0] RAM_LAST = RAM_BASE + ADDR_W'(RAM_BYTES - 1);

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_rx_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && rx_valid_i |=> !ram_we_o);

  p_ram_window_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o >= RAM_BASE) && (ram_addr_o <= RAM_LAST));

  p_we_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);

  p_scan_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_rd_o |-> nvm_addr_o <= (mode_i ? BLANK_END1 : BLANK_END0));

  p_erase_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o);

  p_jump_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |=> jump_o);

  p_jump_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> !tx_valid_o && !ram_we_o);
endmodule

bind boot_dl_ctrl bdl_chk #(
  .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
  .BLANK_END0(BLANK_END0), .BLANK_END1(BLANK_END1)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .rx_valid_i  (rx_valid_i),
  .tx_ready_i  (tx_ready_i),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .nvm_rd_o    (nvm_rd_o),
  .nvm_addr_o  (nvm_addr_o),
  .erase_req_o (erase_req_o),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .jump_o      (jump_o)
);

// File: tb/sim_boot_dl_ctrl.sv
`timescale 1ns/1ps
module sim_boot_dl_ctrl;
  localparam logic [15:0] BASE  = 16'hF7E0;
  localparam int          BYTES = 1934;
  localparam logic [15:0] END0  = 16'h001F;
  localparam logic [15:0] END1  = 16'h003F;

  typedef struct packed {
    logic        mode;
    logic        dirty;
    logic [15:0] daddr;
    logic        efail;
    logic [15:0] len;
    logic [3:0]  n_erase;
    logic [7:0]  reply;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0000, 1'b0, 16'd4,    4'd0, 8'hAA},
    '{1'b0, 1'b1, 16'h001F, 1'b0, 16'd3,    4'd1, 8'hAA},
    '{1'b0, 1'b1, 16'h0020, 1'b0, 16'd2,    4'd0, 8'hAA},
    '{1'b1, 1'b1, 16'h0020, 1'b0, 16'd5,    4'd1, 8'hAA},
    '{1'b1, 1'b1, 16'h0005, 1'b1, 16'd1,    4'd1, 8'hFF},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 16'd0,    4'd0, 8'hAA},
    '{1'b1, 1'b0, 16'h0000, 1'b0, 16'd1935, 4'd0, 8'hAA},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 16'd1934, 4'd0, 8'hAA},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 16'd256,  4'd0, 8'hAA}
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic        rx_valid = 1'b0, tx_ready = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, nvm_rd, erase_req, ram_we, jump;
  logic [7:0]  tx_data, ram_wdata;
  logic [15:0] nvm_addr, ram_addr, jump_addr;
  logic [7:0]  nvm_rdata = 8'hFF;
  logic        erase_done = 1'b0, erase_fail = 1'b0;

  int n_chk = 0, n_err = 0;
  int tx_cnt = 0, tx_seen = 0, ram_cnt = 0, ram_bad = 0, erase_cnt = 0, er_tmr = 0;
  logic [7:0]  tx_last = '0;
  logic [15:0] ram_last = '0;
  logic        dirty = 1'b0, er_fail_sel = 1'b0;
  logic [15:0] daddr = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  boot_dl_ctrl #(.BLANK_END0(END0), .BLANK_END1(END1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .tx_ready_i(tx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .nvm_rd_o(nvm_rd), .nvm_addr_o(nvm_addr), .nvm_rdata_i(nvm_rdata),
    .erase_req_o(erase_req), .erase_done_i(erase_done), .erase_fail_i(erase_fail),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .jump_o(jump), .jump_addr_o(jump_addr)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  // port monitor and memory models, sampled mid-cycle
  always begin
    @(negedge clk); #1;
    if (tx_valid && tx_ready) begin tx_last = tx_data; tx_cnt++; end
    if (ram_we) begin
      if (ram_addr != BASE + 16'(ram_cnt) || ram_wdata != pat(ram_cnt)) ram_bad++;
      ram_last = ram_addr;
      ram_cnt++;
    end
    if (nvm_rd) nvm_rdata = (dirty && nvm_addr == daddr) ? 8'h00 : 8'hFF;
    erase_done = 1'b0;
    erase_fail = 1'b0;
    if (er_tmr > 0) begin
      er_tmr--;
      if (er_tmr == 0) begin
        if (er_fail_sel) erase_fail = 1'b1; else erase_done = 1'b1;
      end
    end
    if (erase_req) begin erase_cnt++; er_tmr = 4; end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; rx_valid = 1'b0; tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    tx_cnt = 0; tx_seen = 0; ram_cnt = 0; ram_bad = 0; erase_cnt = 0; er_tmr = 0;
    rst_n = 1'b1;
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_tx(output logic [7:0] b, output bit ok);
    ok = 1'b0; b = '0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1.5;
      if (tx_cnt > tx_seen) begin
        tx_seen++; b = tx_last; ok = 1'b1;
        return;
      end
    end
  endtask

  task automatic expect_tx(logic [7:0] exp, string req, string what);
    logic [7:0] b;
    bit ok;
    wait_tx(b, ok);
    chk(ok && b == exp, req, what, ok ? int'(b) : -1, int'(exp));
  endtask

  task automatic begin_session(logic m, logic d, logic [15:0] a, logic f);
    do_reset();
    mode = m; dirty = d; daddr = a; er_fail_sel = f;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_vec(vec_t v);
    logic [7:0] b;
    bit ok;
    int echo_bad;
    begin_session(v.mode, v.dirty, v.daddr, v.efail);
    send_byte(8'h3C);
    repeat (8) @(negedge clk);
    #1.5;
    chk(tx_cnt == 0, "R2", "non-sync byte answered", tx_cnt, 0);
    send_byte(8'h55);
    expect_tx(v.reply, v.efail ? "R4" : "R5", "reply after scan");
    chk(erase_cnt == int'(v.n_erase), "R3", "erase requests", erase_cnt, int'(v.n_erase));
    if (v.efail) begin
      send_byte(8'h01);
      repeat (20) @(negedge clk);
      #1.5;
      chk(tx_cnt == 1 && ram_cnt == 0, "R4", "activity after erase error", tx_cnt, 1);
      return;
    end
    send_byte(v.len[15:8]);
    expect_tx(v.len[15:8], "R6", "high length echo");
    send_byte(v.len[7:0]);
    expect_tx(v.len[7:0], "R6", "low length echo");
    if (v.len == 0 || v.len > 16'(BYTES)) begin
      expect_tx(8'hEE, "R7", "length error code");
      send_byte(8'h11);
      repeat (20) @(negedge clk);
      #1.5;
      chk(tx_cnt == 4 && ram_cnt == 0, "R7", "activity after length error", tx_cnt, 4);
      return;
    end
    echo_bad = 0;
    for (int i = 0; i < int'(v.len); i++) begin
      send_byte(pat(i));
      wait_tx(b, ok);
      if (!ok || b != pat(i)) echo_bad++;
    end
    chk(echo_bad == 0, "R8", "program echo mismatches", echo_bad, 0);
    expect_tx(8'hAA, "R9", "final acknowledge");
    repeat (2) @(negedge clk);
    #1.5;
    chk(jump == 1'b1 && jump_addr == BASE, "R9", "jump request", int'(jump_addr), int'(BASE));
    chk(ram_cnt == int'(v.len) && ram_bad == 0, "R8", "RAM writes", ram_cnt, int'(v.len));
    if (v.len == 16'(BYTES))
      chk(ram_last == 16'hFF6D, "R11", "last window address", int'(ram_last), 16'hFF6D);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state and no reaction before start
    do_reset();
    #1.5;
    chk(!tx_valid && !nvm_rd && !erase_req && !ram_we && !jump, "R1", "outputs after reset",
        {tx_valid, nvm_rd, erase_req, ram_we, jump}, 0);
    send_byte(8'h55);
    repeat (20) @(negedge clk);
    #1.5;
    chk(tx_cnt == 0 && erase_cnt == 0 && !tx_valid, "R1", "activity without start", tx_cnt, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R10: stalled transmitter holds data and drops incoming byte
    begin_session(1'b0, 1'b0, 16'h0000, 1'b0);
    send_byte(8'h55);
    expect_tx(8'hAA, "R5", "ack before stall test");
    @(negedge clk); tx_ready = 1'b0;
    send_byte(8'h00);
    repeat (3) @(negedge clk);
    #1.5;
    chk(tx_valid && tx_data == 8'h00, "R10", "held echo while stalled", int'(tx_data), 0);
    send_byte(8'h99);
    @(negedge clk); tx_ready = 1'b1;
    expect_tx(8'h00, "R6", "high echo after stall");
    repeat (6) @(negedge clk);
    #1.5;
    chk(tx_cnt == 2, "R10", "byte during stall dropped", tx_cnt, 2);
    send_byte(8'h02);
    expect_tx(8'h02, "R6", "low echo after stall");
    send_byte(pat(0));
    expect_tx(pat(0), "R8", "echo byte 0");
    send_byte(pat(1));
    expect_tx(pat(1), "R8", "echo byte 1");
    expect_tx(8'hAA, "R9", "final acknowledge after stall");
    chk(ram_cnt == 2 && ram_bad == 0, "R10", "RAM writes after stall", ram_cnt, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule